// File: doc/BRIEF.md
# Embedded-Clock Serializer Link Sequencer

This block runs the control side of a serializer that sends 10-bit parallel words down a single serial line, with clock bits embedded in every frame. It walks the link through sleep, a fixed initialization interval, sync-pattern transmission and normal data transmission. It also gates the line driver's output enable. Each word period lasts twelve bit-clock cycles. Once per period, at the frame boundary, the block samples the parallel word and the two sync request pins. It then shifts out a framed word or a sync frame, one bit per bit-clock cycle.

A low level on the power input sends the block to sleep. In sleep the timing and the shift path stop and the output enable is off. Only a high level on the power input brings the block back. After it wakes, the block spends a full initialization interval before it transmits anything. Dropping the driver enable turns the serial output off and freezes every internal counter and register. When the enable returns, the stream resumes at the bit that would have come next.

Top module: `serlink_ctrl`

## Requirements
- R1: After reset `link_state_o` reads 0 (sleep), `ser_oe_o` is low and `ser_o` is low.
- R2: While `pwr_up_i` is low, the block is in sleep (`link_state_o` = 0) from the next bit-clock edge onward. In sleep `ser_oe_o` stays low whatever `word_i`, the sync pins or `drv_en_i` do.
- R3: Leaving sleep requires `pwr_up_i` high. After wake-up, `link_state_o` reads 1 (initializing) for exactly INIT_FRAMES x 12 bit-clock cycles (6120 by default), with `ser_oe_o` low throughout. Every wake-up restarts this count from zero.
- R4: A data frame is 12 bits in time order: bit 0 is a high clock bit, bits 1 to 10 carry `word_i[0]` to `word_i[9]`, and bit 11 is a low clock bit. `link_state_o` reads 3 while data frames are sent.
- R5: If either sync pin is high at a frame boundary, the next frame is six ones followed by six zeros and `link_state_o` reads 2. The sync frame repeats at every boundary where either pin is still high.
- R6: `word_i` and the sync pins are sampled only at the bit-clock edge that ends a frame. Changes in mid-frame do not alter the frame in flight.
- R7: While `drv_en_i` is low, `ser_oe_o` and `ser_o` are low and the internal position is frozen. When the enable returns, the next bit sent is the one that follows the last bit sent before the freeze. `link_state_o` is unchanged across the freeze.
- R8: `pwr_up_i` low overrides a frozen state: with `drv_en_i` low the block still enters sleep at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; twelve cycles make one word period |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_up_i | input | 1 | Power request; low means sleep |
| drv_en_i | input | 1 | Line-driver enable; low disables the output and freezes state |
| sync_a_i | input | 1 | First sync request pin |
| sync_b_i | input | 1 | Second sync request pin |
| word_i | input | 10 | Parallel word to transmit |
| ser_o | output | 1 | Serial bit stream (low while disabled) |
| ser_oe_o | output | 1 | Output enable for the line driver |
| link_state_o | output | 2 | 0 sleep, 1 initializing, 2 sync, 3 data |

## Verification
The bench counts the initialization interval to the exact cycle, both at first wake-up and after a later sleep. A design that kept a partial count, or that counted bit cycles instead of word periods, would start sending at the wrong moment. It changes the word and a sync pin in mid-frame, which catches a design that samples outside the boundary. It pauses the driver enable in the middle of a frame and reassembles the frame across the pause, so a design that kept shifting while disabled would lose or repeat bits. It also drops power while the output is frozen, to catch a design that lets the freeze mask the sleep request.

// File: rtl/serlink_pkg.sv
package serlink_pkg;

  typedef enum logic [1:0] {
    LS_SLEEP = 2'd0,
    LS_INIT  = 2'd1,
    LS_SYNC  = 2'd2,
    LS_DATA  = 2'd3
  } link_state_e;

  function automatic logic is_sending(link_state_e s);
    return (s == LS_SYNC) || (s == LS_DATA);
  endfunction

endpackage

// File: rtl/serlink_timer.sv
module serlink_timer #(
  parameter int unsigned FRAME_W     = 12,
  parameter int unsigned INIT_FRAMES = 510
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         run,
  input  logic                         count_init,
  input  logic                         pwr_up,
  output logic [$clog2(FRAME_W)-1:0]   bit_cnt,
  output logic                         frame_end,
  output logic                         init_last
);
  localparam int unsigned BW = $clog2(FRAME_W);
  localparam int unsigned IW = $clog2(INIT_FRAMES + 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(FRAME_W - 1);
  localparam logic [IW-1:0] LAST_INIT = IW'(INIT_FRAMES - 1);

  logic [IW-1:0] init_cnt;

  assign frame_end = run && (bit_cnt == LAST_BIT);
  assign init_last = (init_cnt == LAST_INIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      init_cnt <= '0;
    end else if (clear) begin
      bit_cnt  <= '0;
      init_cnt <= '0;
    end else if (run) begin
      bit_cnt <= frame_end ? '0 : bit_cnt + 1'b1;
      if (frame_end && count_init && !init_last)
        init_cnt <= init_cnt + 1'b1;
    end
  end

  AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= LAST_BIT); // R4
  AST_FROZEN_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_up && !run && !clear) |=> $stable(bit_cnt)); // R7

endmodule

// File: rtl/serlink_fsm.sv
module serlink_fsm
  import serlink_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_up,
  input  logic        frame_end,
  input  logic        init_last,
  input  logic        sync_req,
  output link_state_e state,
  output logic        load,
  output logic        clear_tm
);
  link_state_e nxt;

  always_comb begin
    nxt  = state;
    load = 1'b0;
    if (!pwr_up) begin
      nxt = LS_SLEEP;
    end else begin
      unique case (state)
        LS_SLEEP: nxt = LS_INIT;
        LS_INIT: begin
          if (frame_end && init_last) begin
            load = 1'b1;
            nxt  = sync_req ? LS_SYNC : LS_DATA;
          end
        end
        default: begin
          if (frame_end) begin
            load = 1'b1;
            nxt  = sync_req ? LS_SYNC : LS_DATA;
          end
        end
      endcase
    end
  end

  assign clear_tm = (state == LS_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= LS_SLEEP;
    else        state <= nxt;
  end

  AST_POWER_DOWN_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_up |=> (state == LS_SLEEP)); // R2
  AST_INIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LS_INIT && pwr_up && !init_last) |=> (state == LS_INIT)); // R3
  AST_WAKE_TO_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LS_SLEEP && pwr_up) |=> (state == LS_INIT)); // R3

endmodule

// File: rtl/serlink_shifter.sv
module serlink_shifter #(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic              sel_sync,
  input  logic              shift,
  input  logic [DATA_W-1:0] word,
  output logic              bit_out
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned ONES    = FRAME_W / 2;

  function automatic logic [FRAME_W-1:0] data_frame(logic [DATA_W-1:0] w);
    return {1'b0, w, 1'b1};
  endfunction

  function automatic logic [FRAME_W-1:0] sync_frame();
    logic [FRAME_W-1:0] f;
    for (int i = 0; i < FRAME_W; i++) f[i] = (i < ONES);
    return f;
  endfunction

  logic [FRAME_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr <= '0;
    else if (clear)    sr <= '0;
    else if (load)     sr <= sel_sync ? sync_frame() : data_frame(word);
    else if (shift)    sr <= sr >> 1;
  end

  assign bit_out = sr[0];

  AST_FRAME_OPENS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sr[0] == 1'b1)); // R4
  AST_FRAME_CLOSES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sr[FRAME_W-1] == 1'b0)); // R5

endmodule

// File: rtl/serlink_ctrl.sv
module serlink_ctrl
  import serlink_pkg::*;
#(
  parameter int unsigned DATA_W      = 10,
  parameter int unsigned INIT_FRAMES = 510
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_up_i,
  input  logic              drv_en_i,
  input  logic              sync_a_i,
  input  logic              sync_b_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              ser_o,
  output logic              ser_oe_o,
  output logic [1:0]        link_state_o
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned BW      = $clog2(FRAME_W);

  link_state_e   state;
  logic [BW-1:0] bit_cnt;
  logic          frame_end, init_last, load, clear_tm, run, sync_req, tx_bit;

  assign sync_req = sync_a_i | sync_b_i;
  assign run      = pwr_up_i && drv_en_i && (state != LS_SLEEP);

  serlink_timer #(.FRAME_W(FRAME_W), .INIT_FRAMES(INIT_FRAMES)) timer_i (
    .clk(clk), .rst_n(rst_n), .clear(clear_tm), .run(run),
    .count_init(state == LS_INIT), .pwr_up(pwr_up_i),
    .bit_cnt(bit_cnt), .frame_end(frame_end), .init_last(init_last)
  );

  serlink_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up_i), .frame_end(frame_end),
    .init_last(init_last), .sync_req(sync_req), .state(state),
    .load(load), .clear_tm(clear_tm)
  );

  serlink_shifter #(.DATA_W(DATA_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .clear(clear_tm), .load(load),
    .sel_sync(sync_req), .shift(run), .word(word_i), .bit_out(tx_bit)
  );

  assign ser_oe_o     = drv_en_i && is_sending(state);
  assign ser_o        = ser_oe_o & tx_bit;
  assign link_state_o = state;

  AST_OE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ser_oe_o |-> drv_en_i); // R7
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LS_SLEEP) |-> !ser_oe_o); // R2
  AST_FREEZE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_up_i && !drv_en_i && state != LS_SLEEP) |=> $stable(state)); // R7
  AST_LOAD_AT_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (bit_cnt == BW'(FRAME_W - 1))); // R6

endmodule

// File: tb/serlink_ctrl_tb.sv
module serlink_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwr_up, drv_en, sync_a, sync_b;
  logic [9:0] word;
  logic       ser, oe;
  logic [1:0] lst;

  int n_chk = 0;
  int n_bad = 0;

  always #2ns clk = ~clk;

  serlink_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_up_i(pwr_up), .drv_en_i(drv_en),
    .sync_a_i(sync_a), .sync_b_i(sync_b), .word_i(word),
    .ser_o(ser), .ser_oe_o(oe), .link_state_o(lst)
  );

  // {sync_a, sync_b, word}
  localparam logic [11:0] VEC [0:7] = '{
    {2'b00, 10'h3FF}, {2'b00, 10'h000}, {2'b10, 10'h155}, {2'b00, 10'h2AA},
    {2'b01, 10'h0F0}, {2'b11, 10'h001}, {2'b10, 10'h200}, {2'b00, 10'h201}
  };

  function automatic logic [11:0] want(logic sa, logic sb, logic [9:0] w);
    logic [11:0] r;
    if (sa || sb) begin
      for (int i = 0; i < 12; i++) r[i] = (i < 6) ? 1'b1 : 1'b0;
    end else begin
      r[0] = 1'b1;
      for (int i = 0; i < 10; i++) r[i+1] = w[i];
      r[11] = 1'b0;
    end
    return r;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // first sample taken at the current negedge, ends at the negedge of bit 11
  task automatic grab(output logic [11:0] f);
    for (int k = 0; k < 12; k++) begin
      f[k] = ser;
      if (k < 11) @(negedge clk);
    end
  endtask

  task automatic wake_and_count(input string req);
    int  cnt;
    logic oe_seen;
    cnt = 0;
    oe_seen = 1'b0;
    pwr_up = 1'b1;
    @(negedge clk);
    while (lst == 2'd1 && cnt < 7000) begin
      oe_seen |= oe;
      cnt++;
      @(negedge clk);
    end
    chk(cnt == 6120, req, cnt, 6120);
    chk(!oe_seen, {req, " oe during init"}, oe_seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [11:0] f;
    logic        q;
    rst_n = 1'b0; pwr_up = 1'b0; drv_en = 1'b1;
    sync_a = 1'b0; sync_b = 1'b0; word = 10'h2A5;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(lst == 2'd0 && !oe && !ser, "R1", {lst, oe, ser}, 0);
    rst_n = 1'b1;

    // R2 sleep ignores data and sync activity
    q = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      word = 10'(i * 37); sync_a = i[0]; sync_b = i[1]; drv_en = i[2];
      q |= oe || (lst != 2'd0);
    end
    chk(!q, "R2 sleep ignores inputs", q, 0);
    sync_a = 1'b0; sync_b = 1'b0; drv_en = 1'b1; word = 10'h2A5;

    // R3 initialization length
    wake_and_count("R3 init length");
    chk(lst == 2'd3, "R4 state data", lst, 3);
    grab(f);
    chk(f == want(1'b0, 1'b0, 10'h2A5), "R4 first frame", f, want(1'b0, 1'b0, 10'h2A5));

    // R4 / R5 table of vectors
    for (int v = 0; v < 8; v++) begin
      sync_a = VEC[v][11]; sync_b = VEC[v][10]; word = VEC[v][9:0];
      @(negedge clk);
      chk(lst == ((VEC[v][11] | VEC[v][10]) ? 2'd2 : 2'd3), "R5 state code", lst,
          (VEC[v][11] | VEC[v][10]) ? 2 : 3);
      grab(f);
      chk(f == want(VEC[v][11], VEC[v][10], VEC[v][9:0]), "R4/R5 frame", f,
          want(VEC[v][11], VEC[v][10], VEC[v][9:0]));
    end

    // R6 mid-frame changes do not alter the frame in flight
    sync_a = 1'b0; sync_b = 1'b0; word = 10'h1C3;
    @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      f[k] = ser;
      if (k == 5) begin word = 10'h23C; sync_a = 1'b1; end
      if (k < 11) @(negedge clk);
    end
    chk(f == want(1'b0, 1'b0, 10'h1C3), "R6 frame kept", f, want(1'b0, 1'b0, 10'h1C3));
    @(negedge clk);
    grab(f);
    chk(f == want(1'b1, 1'b0, 10'h23C), "R6 sync taken at boundary", f, 12'h03F);

    // R7 freeze in mid-frame
    sync_a = 1'b0; word = 10'h0B6;
    @(negedge clk);
    q = 1'b0;
    for (int k = 0; k < 12; k++) begin
      f[k] = ser;
      if (k == 4) begin
        drv_en = 1'b0;
        for (int j = 0; j < 7; j++) begin
          @(negedge clk);
          q |= oe || ser || (lst != 2'd3);
        end
        drv_en = 1'b1;
      end
      if (k < 11) @(negedge clk);
    end
    chk(!q, "R7 output off while frozen", q, 0);
    chk(f == want(1'b0, 1'b0, 10'h0B6), "R7 resumed frame", f, want(1'b0, 1'b0, 10'h0B6));

    // R8 power-down while frozen
    @(negedge clk);
    drv_en = 1'b0;
    repeat (3) @(negedge clk);
    pwr_up = 1'b0;
    @(negedge clk);
    chk(lst == 2'd0, "R8 sleep while frozen", lst, 0);
    drv_en = 1'b1;
    repeat (2) @(negedge clk);
    chk(lst == 2'd0 && !oe, "R2 stays asleep", {lst, oe}, 0);

    // R3 restart from zero, R5 second pin alone
    sync_b = 1'b1;
    wake_and_count("R3 restart");
    chk(lst == 2'd2, "R5 state sync after wake", lst, 2);
    grab(f);
    chk(f == 12'h03F, "R5 sync frame after wake", f, 12'h03F);
    @(negedge clk);
    grab(f);
    chk(f == 12'h03F, "R5 sync repeats", f, 12'h03F);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule